// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserve / Store-Conditional Pairs

This block keeps the atomic-update reservations of a processor with several hardware threads. The issue stage hands it one instruction word per cycle, with the issuing thread number and the two operand register values. The block decodes the word into a load-and-reserve or a store-conditional and forms the 32-bit effective address. A load-and-reserve reads one word from memory, returns it zero-extended for the destination register, and records the 128-byte line it came from as that thread's reservation. A store-conditional is reported as passed only when its thread still holds a reservation on the addressed line.

Reservations are lost in four ways. A store from another agent, seen on the snoop port, kills the reservation of every thread that holds the touched line. An exception or context-switch event kills the reservation of its own thread. A store-conditional always uses up its thread's reservation. A later load-and-reserve from the same thread replaces it. Misaligned requests raise an alignment exception instead of completing. Results appear one clock after the request, and the memory address is offered in the request cycle so that a single-cycle memory can return its data in that same cycle.

Top module: `lrsc_monitor`

## Requirements
- R1: Only words with bits [31:26] = 31 are recognized (instruction bit 0 is the MSB, word bit 31). With bits [10:1] = 20 the word is a load-and-reserve. With bits [10:1] = 150 and bit [0] = 1 it is a store-conditional. Any other word gives no response and leaves every reservation unchanged.
- R2: The effective address is the low 32 bits of base + index. The base is zero when the RA field (bits [20:16]) is 0, whatever value is on `req_base`. The address is driven on `mem_addr` in the request cycle.
- R3: An aligned load-and-reserve raises `rd_we` one cycle later. `rd_idx` then equals bits [25:21] of the word, and `rd_wdata` equals `mem_rdata` zero-extended to 64 bits. `mem_rd_en` is high in the request cycle.
- R4: The reservation covers the 128-byte line holding the address (bits [31:7]). A store-conditional anywhere in that line can pass. One in a different line fails.
- R5: Each thread holds at most one reservation. A new load-and-reserve from a thread replaces that thread's earlier line.
- R6: A snoop store to a line clears the reservation of every thread holding that line. A snoop store to a different line clears none.
- R7: An exception or context-switch event for a thread clears that thread's reservation only.
- R8: A load-and-reserve or store-conditional whose address has bits [1:0] not zero raises `align_exc` one cycle later. It writes no register, sets no reservation, reports a failed store-conditional (`sc_done` = 1, `sc_eq` = 0), and clears the issuing thread's reservation.
- R9: A store-conditional raises `sc_done` one cycle later. `sc_eq` is 1 exactly when the thread held a valid reservation on the addressed line, and 0 otherwise.
- R10: A store-conditional clears its thread's reservation whether it passes or fails.
- R11: A snoop store to the line of a store-conditional in the same cycle makes that store-conditional fail.
- R12: Reset clears every reservation and the response flags `rd_we`, `align_exc`, `sc_done` and `sc_eq`.
- R13: When a load-and-reserve meets an exception or context-switch event for its own thread in the same cycle, the register is still written but no reservation remains. A snoop hit on the thread's previous line in the same cycle does not stop the new reservation from being set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_tid | input | 2 (log2 NUM_THREADS) | Issuing hardware thread |
| req_insn | input | 32 | Instruction word |
| req_base | input | 64 | Value of the register named by the RA field |
| req_index | input | 64 | Value of the register named by the RB field |
| mem_rd_en | output | 1 | Word read request for an aligned load-and-reserve |
| mem_addr | output | 32 | Effective address |
| mem_rdata | input | 32 | Word read at `mem_addr`, valid in the same cycle |
| snp_valid | input | 1 | Store by another agent seen this cycle |
| snp_addr | input | 32 | Address of that store |
| exc_evt | input | 4 (NUM_THREADS) | Exception taken, one bit per thread |
| ctx_evt | input | 4 (NUM_THREADS) | Context switch, one bit per thread |
| rd_we | output | 1 | Destination register write |
| rd_idx | output | 5 | Destination register number |
| rd_wdata | output | 64 | Zero-extended loaded word |
| align_exc | output | 1 | Alignment exception for the previous request |
| sc_done | output | 1 | Store-conditional result valid |
| sc_eq | output | 1 | Store-conditional passed (EQ bit of the condition result) |

## Verification
The main function is driven with load/store-conditional pairs in several forms: the same word, another word in the same line, and the next line up, which separate line-granular from word-granular matching. Pairs from two threads on one line under a snoop, an exception or a context switch show whether a kill reaches every holder or only its own thread. Collisions in one cycle (snoop with store-conditional, snoop or exception with a new load-and-reserve) fix the priority order. Zero RA fields, 64-bit carries and near-miss instruction words check address forming and decoding.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam int unsigned INSN_W    = 32;
  localparam int unsigned GPR_W     = 64;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned REG_IDX_W = 5;

  typedef enum logic [1:0] {
    REQ_NONE       = 2'd0,
    REQ_LOAD_RSV   = 2'd1,
    REQ_STORE_COND = 2'd2
  } req_kind_e;
endpackage

// File: rtl/lrsc_rst_sync.sv
module lrsc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lrsc_decode.sv
module lrsc_decode
  import lrsc_pkg::*;
#(
  parameter int unsigned PRIM_OP       = 31,
  parameter int unsigned XO_LOAD_RSV   = 20,
  parameter int unsigned XO_STORE_COND = 150,
  parameter int unsigned EA_W          = 32,
  parameter int unsigned ALIGN_BITS    = 2
) (
  input  logic                 valid,
  input  logic [INSN_W-1:0]    insn,
  input  logic [GPR_W-1:0]     base_val,
  input  logic [GPR_W-1:0]     index_val,
  output req_kind_e            kind,
  output logic [REG_IDX_W-1:0] rt,
  output logic [EA_W-1:0]      ea,
  output logic                 misaligned
);
  logic [5:0]           prim;
  logic [REG_IDX_W-1:0] ra;
  logic [9:0]           xo;
  logic                 rc;
  logic [GPR_W-1:0]     base_eff;
  logic [GPR_W-1:0]     sum;
  logic                 unused_bits;

  // field positions: instruction bit 0 is the MSB of the word
  assign prim = insn[31:26];
  assign rt   = insn[25:21];
  assign ra   = insn[20:16];
  assign xo   = insn[10:1];
  assign rc   = insn[0];

  always_comb begin
    kind = REQ_NONE;
    if (valid && prim == 6'(PRIM_OP)) begin
      if (xo == 10'(XO_LOAD_RSV))
        kind = REQ_LOAD_RSV;
      else if (xo == 10'(XO_STORE_COND) && rc)
        kind = REQ_STORE_COND;
    end
  end

  always_comb begin
    base_eff   = (ra == '0) ? '0 : base_val;
    sum        = base_eff + index_val;
    ea         = sum[EA_W-1:0];
    misaligned = |ea[ALIGN_BITS-1:0];
  end

  assign unused_bits = ^{insn[15:11], sum[GPR_W-1:EA_W]};
endmodule

// File: rtl/lrsc_rsv_slot.sv
module lrsc_rsv_slot #(
  parameter int unsigned TAG_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             kill,
  input  logic             sc_clr,
  input  logic             snp_valid,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] query_tag,
  output logic             rsv_valid,
  output logic             rsv_hit
);
  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q;
  logic             tag_en;
  logic             snp_hit;

  always_comb begin
    snp_hit = valid_q && snp_valid && (snp_tag == tag_q);
    valid_d = valid_q;
    tag_en  = 1'b0;
    if (kill) begin
      valid_d = 1'b0;
    end else if (set_en) begin
      valid_d = 1'b1;
      tag_en  = 1'b1;
    end else if (snp_hit || sc_clr) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (tag_en) tag_q <= set_tag;
  end

  assign rsv_valid = valid_q;
  assign rsv_hit   = valid_q && (tag_q == query_tag);

  p_kill_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !rsv_valid);
  p_set_records_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !kill) |=> (rsv_valid && tag_q == $past(set_tag)));
  p_snoop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && !set_en) |=> !rsv_valid);
  p_sc_consumes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_clr && !set_en) |=> !rsv_valid);
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int unsigned NUM_THREADS   = 4,
  parameter int unsigned EA_W          = 32,
  parameter int unsigned LINE_BYTES    = 128,
  parameter int unsigned PRIM_OP       = 31,
  parameter int unsigned XO_LOAD_RSV   = 20,
  parameter int unsigned XO_STORE_COND = 150,
  localparam int unsigned TID_W     = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int unsigned LINE_BITS = $clog2(LINE_BYTES),
  localparam int unsigned TAG_W     = EA_W - LINE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [TID_W-1:0]     req_tid,
  input  logic [INSN_W-1:0]    req_insn,
  input  logic [GPR_W-1:0]     req_base,
  input  logic [GPR_W-1:0]     req_index,
  output logic                 mem_rd_en,
  output logic [EA_W-1:0]      mem_addr,
  input  logic [WORD_W-1:0]    mem_rdata,
  input  logic                 snp_valid,
  input  logic [EA_W-1:0]      snp_addr,
  input  logic [NUM_THREADS-1:0] exc_evt,
  input  logic [NUM_THREADS-1:0] ctx_evt,
  output logic                 rd_we,
  output logic [REG_IDX_W-1:0] rd_idx,
  output logic [GPR_W-1:0]     rd_wdata,
  output logic                 align_exc,
  output logic                 sc_done,
  output logic                 sc_eq
);
  logic                   srst_n;
  req_kind_e              kind;
  logic [REG_IDX_W-1:0]   rt;
  logic [EA_W-1:0]        ea;
  logic                   mis;
  logic                   is_lr, is_sc;
  logic [TAG_W-1:0]       req_tag, snp_tag;
  logic [NUM_THREADS-1:0] tid_sel, rsv_hit, rsv_valid;
  logic                   hit_sel, evt_sel, snp_conflict, sc_pass;
  logic                   unused_bits;

  logic                   rd_we_d, align_d, sc_done_d, sc_eq_d, payload_en;
  logic                   rd_we_q, align_q, sc_done_q, sc_eq_q;
  logic [REG_IDX_W-1:0]   rd_idx_q;
  logic [GPR_W-1:0]       rd_wdata_q;

  lrsc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lrsc_decode #(
    .PRIM_OP       (PRIM_OP),
    .XO_LOAD_RSV   (XO_LOAD_RSV),
    .XO_STORE_COND (XO_STORE_COND),
    .EA_W          (EA_W),
    .ALIGN_BITS    (2)
  ) u_dec (
    .valid      (req_valid),
    .insn       (req_insn),
    .base_val   (req_base),
    .index_val  (req_index),
    .kind       (kind),
    .rt         (rt),
    .ea         (ea),
    .misaligned (mis)
  );

  assign is_lr   = (kind == REQ_LOAD_RSV);
  assign is_sc   = (kind == REQ_STORE_COND);
  assign req_tag = ea[EA_W-1:LINE_BITS];
  assign snp_tag = snp_addr[EA_W-1:LINE_BITS];

  assign mem_rd_en = is_lr && !mis;
  assign mem_addr  = ea;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic set_en, kill, sc_clr;
    assign tid_sel[t] = req_valid && (req_tid == TID_W'(t));
    assign set_en     = tid_sel[t] && is_lr && !mis;
    assign kill       = exc_evt[t] || ctx_evt[t] || (tid_sel[t] && (is_lr || is_sc) && mis);
    assign sc_clr     = tid_sel[t] && is_sc;

    lrsc_rsv_slot #(.TAG_W(TAG_W)) u_slot (
      .clk       (clk),
      .rst_n     (srst_n),
      .set_en    (set_en),
      .set_tag   (req_tag),
      .kill      (kill),
      .sc_clr    (sc_clr),
      .snp_valid (snp_valid),
      .snp_tag   (snp_tag),
      .query_tag (req_tag),
      .rsv_valid (rsv_valid[t]),
      .rsv_hit   (rsv_hit[t])
    );
  end

  always_comb begin
    hit_sel      = |(rsv_hit & tid_sel);
    evt_sel      = |((exc_evt | ctx_evt) & tid_sel);
    snp_conflict = snp_valid && (snp_tag == req_tag);
    sc_pass      = is_sc && !mis && hit_sel && !snp_conflict && !evt_sel;
  end

  // response next state
  always_comb begin
    rd_we_d    = is_lr && !mis;
    align_d    = (is_lr || is_sc) && mis;
    sc_done_d  = is_sc;
    sc_eq_d    = sc_pass;
    payload_en = rd_we_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_we_q   <= 1'b0;
      align_q   <= 1'b0;
      sc_done_q <= 1'b0;
      sc_eq_q   <= 1'b0;
    end else begin
      rd_we_q   <= rd_we_d;
      align_q   <= align_d;
      sc_done_q <= sc_done_d;
      sc_eq_q   <= sc_eq_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_idx_q   <= '0;
      rd_wdata_q <= '0;
    end else if (payload_en) begin
      rd_idx_q   <= rt;
      rd_wdata_q <= {{(GPR_W-WORD_W){1'b0}}, mem_rdata};
    end
  end

  assign rd_we     = rd_we_q;
  assign rd_idx    = rd_idx_q;
  assign rd_wdata  = rd_wdata_q;
  assign align_exc = align_q;
  assign sc_done   = sc_done_q;
  assign sc_eq     = sc_eq_q;

  assign unused_bits = ^{snp_addr[LINE_BITS-1:0], rsv_valid};

  p_one_response_r1: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({rd_we, sc_done}));
  p_misaligned_no_write_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (is_lr && mis) |=> (align_exc && !rd_we));
  p_no_rsv_fails_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (is_sc && !hit_sel) |=> (sc_done && !sc_eq));
  p_snoop_beats_sc_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (is_sc && snp_conflict) |=> (sc_done && !sc_eq));
endmodule

// File: tb/lrsc_monitor_test.sv
module lrsc_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_tid;
  logic [31:0] req_insn;
  logic [63:0] req_base, req_index;
  logic        mem_rd_en;
  logic [31:0] mem_addr, mem_rdata;
  logic        snp_valid;
  logic [31:0] snp_addr;
  logic [3:0]  exc_evt, ctx_evt;
  logic        rd_we, align_exc, sc_done, sc_eq;
  logic [4:0]  rd_idx;
  logic [63:0] rd_wdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] addr_seen;
  logic        rden_seen;

  always #4 clk = ~clk;

  lrsc_monitor uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
    .req_insn(req_insn), .req_base(req_base), .req_index(req_index),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .exc_evt(exc_evt), .ctx_evt(ctx_evt),
    .rd_we(rd_we), .rd_idx(rd_idx), .rd_wdata(rd_wdata), .align_exc(align_exc),
    .sc_done(sc_done), .sc_eq(sc_eq)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {~a[15:0], a[31:16]} ^ 32'hA5A5_0F0F;
  endfunction

  always_comb mem_rdata = mem_word(mem_addr);

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
                                     input logic [4:0] ra, input logic [9:0] xo, input logic rc);
    return {op, rt, ra, 5'd4, xo, rc};
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [31:0] insn, input logic [1:0] tid,
                       input logic [63:0] base, input logic [63:0] idx,
                       input logic sv, input logic [31:0] sa,
                       input logic [3:0] ex, input logic [3:0] cx);
    @(negedge clk);
    req_valid = v; req_insn = insn; req_tid = tid; req_base = base; req_index = idx;
    snp_valid = sv; snp_addr = sa; exc_evt = ex; ctx_evt = cx;
    #1;
    addr_seen = mem_addr;
    rden_seen = mem_rd_en;
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    issue(1'b0, 32'h0, 2'd0, 64'h0, 64'h0, 1'b0, 32'h0, 4'h0, 4'h0);
  endtask

  // kind: 0 idle, 1 load-reserve, 2 store-conditional, 3 other instruction
  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  tid;
    logic [4:0]  ra;
    logic [31:0] base;
    logic [31:0] idx;
    logic        sv;
    logic [31:0] sa;
    logic [3:0]  ex;
    logic [3:0]  cx;
    logic        e_we;
    logic        e_al;
    logic        e_done;
    logic        e_eq;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{2'd1,2'd0,5'd3,32'h1000,32'h10,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd3},     // R3
    '{2'd2,2'd0,5'd3,32'h1000,32'h7C,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b1,4'd4},     // R4 same line
    '{2'd2,2'd0,5'd3,32'h1000,32'h7C,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,4'd10},    // R10
    '{2'd1,2'd1,5'd0,32'hDEAD,32'h2000,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd2},   // R2 ra=0
    '{2'd2,2'd1,5'd0,32'h0,32'h2080,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,4'd4},      // R4 next line
    '{2'd1,2'd1,5'd3,32'h2000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd5},      // R5
    '{2'd1,2'd1,5'd3,32'h3000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd5},      // R5 replace
    '{2'd2,2'd1,5'd3,32'h2000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,4'd5},      // R5 old line lost
    '{2'd1,2'd2,5'd3,32'h4000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd6},      // R6
    '{2'd1,2'd3,5'd3,32'h4000,32'h40,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd6},     // R6
    '{2'd0,2'd0,5'd0,32'h0,32'h0,1'b1,32'h4010,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,4'd6},      // R6 snoop
    '{2'd2,2'd2,5'd3,32'h4000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,4'd6},      // R6
    '{2'd2,2'd3,5'd3,32'h4040,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,4'd6},      // R6
    '{2'd1,2'd0,5'd3,32'h5000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd6},      // R6
    '{2'd0,2'd0,5'd0,32'h0,32'h0,1'b1,32'h5080,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,4'd6},      // R6 other line
    '{2'd2,2'd0,5'd3,32'h5004,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b1,4'd6},      // R6 survives
    '{2'd1,2'd0,5'd3,32'h6000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd7},      // R7
    '{2'd1,2'd1,5'd3,32'h6000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd7},      // R7
    '{2'd0,2'd0,5'd0,32'h0,32'h0,1'b0,32'h0,4'h1,4'h0,1'b0,1'b0,1'b0,1'b0,4'd7},         // R7 exc t0
    '{2'd2,2'd1,5'd3,32'h6000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b1,4'd7},      // R7 t1 kept
    '{2'd2,2'd0,5'd3,32'h6000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,4'd7},      // R7 t0 lost
    '{2'd1,2'd2,5'd3,32'h7000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd7},      // R7
    '{2'd0,2'd0,5'd0,32'h0,32'h0,1'b0,32'h0,4'h0,4'h4,1'b0,1'b0,1'b0,1'b0,4'd7},         // R7 ctx t2
    '{2'd2,2'd2,5'd3,32'h7000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,4'd7},      // R7
    '{2'd1,2'd3,5'd3,32'h8000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd8},      // R8
    '{2'd1,2'd3,5'd3,32'h8002,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b1,1'b0,1'b0,4'd8},      // R8 misaligned LR
    '{2'd2,2'd3,5'd3,32'h8000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,4'd8},      // R8 cleared
    '{2'd1,2'd0,5'd3,32'h9000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd8},      // R8
    '{2'd2,2'd0,5'd3,32'h9001,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b1,1'b1,1'b0,4'd8},      // R8 misaligned SC
    '{2'd2,2'd0,5'd3,32'h9000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,4'd8},      // R8 cleared
    '{2'd1,2'd1,5'd3,32'hA000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd11},     // R11
    '{2'd2,2'd1,5'd3,32'hA000,32'h0,1'b1,32'hA020,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,4'd11},  // R11 collision
    '{2'd1,2'd2,5'd3,32'hB000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd1},      // R1
    '{2'd3,2'd2,5'd3,32'hB000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,4'd1},      // R1 other xo
    '{2'd2,2'd2,5'd3,32'hB000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b1,4'd1},      // R1 untouched
    '{2'd1,2'd0,5'd3,32'hC000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd13},     // R13
    '{2'd1,2'd0,5'd3,32'hD000,32'h0,1'b1,32'hC000,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd13},  // R13 snoop old
    '{2'd2,2'd0,5'd3,32'hD000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b1,4'd13},     // R13
    '{2'd1,2'd1,5'd3,32'hE000,32'h0,1'b0,32'h0,4'h2,4'h0,1'b1,1'b0,1'b0,1'b0,4'd13},     // R13 exc same cycle
    '{2'd2,2'd1,5'd3,32'hE000,32'h0,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,4'd13},     // R13
    '{2'd1,2'd2,5'd3,32'hFFFFFF00,32'h200,1'b0,32'h0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,4'd2},// R2 wrap
    '{2'd2,2'd2,5'd0,32'h0,32'h100,1'b0,32'h0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b1,4'd2}        // R2
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R0 actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    req_valid = 1'b0; req_insn = '0; req_tid = '0; req_base = '0; req_index = '0;
    snp_valid = 1'b0; snp_addr = '0; exc_evt = '0; ctx_evt = '0;
    repeat (3) @(posedge clk);
    #2;
    // R12: flags low in reset
    chk("R12 rd_we in reset", 64'(rd_we), 64'd0);
    chk("R12 align_exc in reset", 64'(align_exc), 64'd0);
    chk("R12 sc_done in reset", 64'(sc_done), 64'd0);
    chk("R12 sc_eq in reset", 64'(sc_eq), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      automatic logic [31:0] insn;
      automatic logic [31:0] ea;
      automatic logic [4:0]  rt = 5'(i + 1);
      case (v.kind)
        2'd1:    insn = mk(6'd31, rt, v.ra, 10'd20, 1'b0);
        2'd2:    insn = mk(6'd31, rt, v.ra, 10'd150, 1'b1);
        2'd3:    insn = mk(6'd31, rt, v.ra, 10'd21, 1'b0);
        default: insn = 32'h0;
      endcase
      ea = ((v.ra == 5'd0) ? 32'h0 : v.base) + v.idx;
      issue(v.kind != 2'd0, insn, v.tid, {32'h0, v.base}, {32'h0, v.idx},
            v.sv, v.sa, v.ex, v.cx);
      if (v.kind == 2'd1 || v.kind == 2'd2)
        chk($sformatf("R2 mem_addr vec %0d", i), 64'(addr_seen), 64'(ea));
      if (v.kind == 2'd1)
        chk($sformatf("R3 mem_rd_en vec %0d", i), 64'(rden_seen), 64'(v.e_we));
      chk($sformatf("R%0d rd_we vec %0d", v.rq, i), 64'(rd_we), 64'(v.e_we));
      chk($sformatf("R%0d align_exc vec %0d", v.rq, i), 64'(align_exc), 64'(v.e_al));
      chk($sformatf("R%0d sc_done vec %0d", v.rq, i), 64'(sc_done), 64'(v.e_done));
      chk($sformatf("R%0d sc_eq vec %0d", v.rq, i), 64'(sc_eq), 64'(v.e_eq));
      if (v.e_we) begin
        chk($sformatf("R3 rd_idx vec %0d", i), 64'(rd_idx), 64'(rt));
        chk($sformatf("R3 rd_wdata vec %0d", i), rd_wdata, {32'h0, mem_word(ea)});
      end
    end

    // R2: 64-bit carry and high bits dropped
    issue(1'b1, mk(6'd31, 5'd9, 5'd7, 10'd20, 1'b0), 2'd1,
          64'hFFFF_FFFF_0000_1000, 64'h0000_0001_0000_0010, 1'b0, 32'h0, 4'h0, 4'h0);
    chk("R2 mem_addr 64-bit operands", 64'(addr_seen), 64'h1010);
    chk("R3 rd_wdata 64-bit operands", rd_wdata, {32'h0, mem_word(32'h1010)});
    issue(1'b1, mk(6'd31, 5'd9, 5'd0, 10'd150, 1'b1), 2'd1,
          64'h0, 64'h1014, 1'b0, 32'h0, 4'h0, 4'h0);
    chk("R2 sc after 64-bit operands", 64'(sc_eq), 64'd1);

    // R1: near-miss words are ignored
    issue(1'b1, mk(6'd31, 5'd2, 5'd3, 10'd20, 1'b0), 2'd3,
          64'h2200, 64'h0, 1'b0, 32'h0, 4'h0, 4'h0);
    issue(1'b1, mk(6'd30, 5'd2, 5'd3, 10'd20, 1'b0), 2'd3,
          64'h2400, 64'h0, 1'b0, 32'h0, 4'h0, 4'h0);
    chk("R1 wrong primary opcode no write", 64'(rd_we), 64'd0);
    issue(1'b1, mk(6'd31, 5'd2, 5'd3, 10'd150, 1'b0), 2'd3,
          64'h2200, 64'h0, 1'b0, 32'h0, 4'h0, 4'h0);
    chk("R1 store-cond without rc no result", 64'(sc_done), 64'd0);
    issue(1'b1, mk(6'd31, 5'd2, 5'd3, 10'd150, 1'b1), 2'd3,
          64'h2200, 64'h0, 1'b0, 32'h0, 4'h0, 4'h0);
    chk("R1 reservation kept after ignored words", 64'(sc_eq), 64'd1);

    // R9: store-conditional with no reservation ever
    issue(1'b1, mk(6'd31, 5'd2, 5'd3, 10'd150, 1'b1), 2'd2,
          64'h3300, 64'h0, 1'b0, 32'h0, 4'h0, 4'h0);
    chk("R9 sc_done without reservation", 64'(sc_done), 64'd1);
    chk("R9 sc_eq without reservation", 64'(sc_eq), 64'd0);

    // R12: reset drops a live reservation
    issue(1'b1, mk(6'd31, 5'd2, 5'd3, 10'd20, 1'b0), 2'd0,
          64'hF000, 64'h0, 1'b0, 32'h0, 4'h0, 4'h0);
    idle();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    issue(1'b1, mk(6'd31, 5'd2, 5'd3, 10'd150, 1'b1), 2'd0,
          64'hF000, 64'h0, 1'b0, 32'h0, 4'h0, 4'h0);
    chk("R12 sc_done after reset", 64'(sc_done), 64'd1);
    chk("R12 reservation gone after reset", 64'(sc_eq), 64'd0);
    idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule